// File: doc/BRIEF.md
# Accumulator ALU and Instruction Execute Unit

This block is the data half of a small 8-bit accumulator machine with 14-bit instruction words. Each cycle in which the execute strobe is high, it decodes the instruction word and combines the working register W with either the 8-bit operand from the file register port or the literal inside the instruction. It sends the result either to W or back to the file register. It also raises a skip request for the conditional-skip instructions, so that the sequencer outside can drop the next instruction.

W and the three status flags (carry C, digit carry DC, zero Z) live inside the block and change on the clock edge that ends an execute cycle. The file address, write data, write enable and skip request are combinational from the instruction and operand while the strobe is high. The sequencer therefore samples them in the same cycle it presents the operand. Program flow, the return stack and the memories belong to the neighbouring blocks.

Top module: `acc_exec_unit`

## Requirements
- R1: While reset is low, W, C, DC and Z are 0 and file_we and skip are 0. Reset takes effect without a clock edge. Its release reaches the registers through a two-stage synchroniser.
- R2: Instruction bits [13:12] pick the class: 00 byte, 01 bit, 11 literal, 10 transfer. For byte instructions, file_addr is bits [6:0] and bit 7 picks the target: 0 sends the result to W, 1 sends it to the file register (file_we high).
- R3: Byte opcodes in bits [11:8] are 0111 add and 0010 subtract (operand minus W). They set C from the carry out of bit 7, DC from the carry out of bit 3, and Z from a zero result. For subtraction, a carry means no borrow.
- R4: 0101 AND, 0100 OR, 0110 XOR, 1001 complement, 1000 move, and 0001 clear (bit 7 = 1 clears the file register, bit 7 = 0 clears W) change only Z.
- R5: 1010 increment and 0011 decrement change only Z. 1111 increment-skip and 1011 decrement-skip leave all flags alone and raise skip when their result is zero.
- R6: 1101 rotates the operand left through C, and 1100 rotates it right through C. Together with C this is a 9-bit rotation, and only C changes.
- R7: 1110 swaps the two nibbles of the operand without touching flags. 0000 with bit 7 = 1 writes W to the file register without touching flags.
- R8: In bit instructions, bits [11:10] are the opcode and bits [9:7] the bit index. 00 clears the chosen bit and 01 sets it. The modified byte is written back to the file register, and flags stay unchanged.
- R9: Bit opcode 10 raises skip when the chosen bit is 0, and 11 raises skip when it is 1. Neither writes anything.
- R10: Literal bits [11:8] select the operation on the literal in bits [7:0], with W as the destination: 111x add, 110x subtract (literal minus W), both setting C, DC and Z; 1001 AND, 1000 OR and 1010 XOR, setting Z; 00xx and 01xx load the literal with no flag change.
- R11: The transfer class (10), byte opcode 0000 with bit 7 = 0, and literal 1011 do nothing: no file write, no skip, and no change to W or the flags.
- R12: While the execute strobe is low, file_we and skip stay 0, and W and the flags hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Execute strobe: the instruction is carried out this cycle |
| instr | input | 14 | Instruction word |
| file_rdata | input | 8 | Operand read from the addressed file register |
| file_addr | output | 7 | File register address, bits [6:0] of the instruction |
| file_wdata | output | 8 | Result to write to the file register |
| file_we | output | 1 | File register write enable |
| w_reg | output | 8 | Working register W |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_dc | output | 1 | Digit carry / no-borrow from bit 3 |
| flag_z | output | 1 | Zero flag |
| skip | output | 1 | Request to skip the next instruction |

## Verification
The hardest condition to reach from the ports is an exact starting state of W and the carry flags before a flag-sensitive instruction. W can only be loaded, and C can only be set, by executing other instructions through the same unit. Before every table entry, the stimulus runs a short preamble that acts as its own test: either a move of 0xFF followed by an add of 1 (leaving C = DC = Z = 1), or a move of 0 followed by an add of 0 (leaving all three 0 apart from Z), and then a literal load of the wanted W. This makes each "flag unchanged" outcome observable against a known value, including the Z that a skip or swap must not touch.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;
  localparam int DW    = 8;   // data path width
  localparam int AW    = 7;   // file register address width
  localparam int IW    = 14;  // instruction width
  localparam int BIW   = $clog2(DW);
  localparam int NIB   = 4;   // digit-carry boundary

  typedef enum logic [4:0] {
    OP_NOP, OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR, OP_CLR, OP_COM,
    OP_DEC, OP_INC, OP_PASS, OP_PASSW, OP_RL, OP_RR, OP_SWAP,
    OP_BCLR, OP_BSET, OP_BTST
  } alu_op_e;

  typedef enum logic [1:0] {SK_NONE, SK_ZERO, SK_BIT0, SK_BIT1} skip_e;

  typedef struct packed {
    alu_op_e op;
    logic    use_lit;
    logic    to_w;
    logic    to_f;
    logic    upd_c;
    logic    upd_dc;
    logic    upd_z;
    skip_e   skip;
  } ctrl_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_exec_pkg::*;
(
  input  logic [IW-1:0] instr,
  output ctrl_t         ctrl
);
  logic dsel;
  assign dsel = instr[7];

  always_comb begin
    ctrl = '0;
    unique case (instr[13:12])
      2'b00: begin
        ctrl.to_w = ~dsel;
        ctrl.to_f = dsel;
        unique case (instr[11:8])
          4'h0: begin
            if (dsel) ctrl.op = OP_PASSW;
            else begin ctrl.to_w = 1'b0; ctrl.to_f = 1'b0; end
          end
          4'h1: begin ctrl.op = OP_CLR;  ctrl.upd_z = 1'b1; end
          4'h2: begin ctrl.op = OP_SUB;  ctrl.upd_c = 1'b1; ctrl.upd_dc = 1'b1; ctrl.upd_z = 1'b1; end
          4'h3: begin ctrl.op = OP_DEC;  ctrl.upd_z = 1'b1; end
          4'h4: begin ctrl.op = OP_IOR;  ctrl.upd_z = 1'b1; end
          4'h5: begin ctrl.op = OP_AND;  ctrl.upd_z = 1'b1; end
          4'h6: begin ctrl.op = OP_XOR;  ctrl.upd_z = 1'b1; end
          4'h7: begin ctrl.op = OP_ADD;  ctrl.upd_c = 1'b1; ctrl.upd_dc = 1'b1; ctrl.upd_z = 1'b1; end
          4'h8: begin ctrl.op = OP_PASS; ctrl.upd_z = 1'b1; end
          4'h9: begin ctrl.op = OP_COM;  ctrl.upd_z = 1'b1; end
          4'hA: begin ctrl.op = OP_INC;  ctrl.upd_z = 1'b1; end
          4'hB: begin ctrl.op = OP_DEC;  ctrl.skip = SK_ZERO; end
          4'hC: begin ctrl.op = OP_RR;   ctrl.upd_c = 1'b1; end
          4'hD: begin ctrl.op = OP_RL;   ctrl.upd_c = 1'b1; end
          4'hE: begin ctrl.op = OP_SWAP; end
          default: begin ctrl.op = OP_INC; ctrl.skip = SK_ZERO; end
        endcase
      end
      2'b01: begin
        unique case (instr[11:10])
          2'b00:   begin ctrl.op = OP_BCLR; ctrl.to_f = 1'b1; end
          2'b01:   begin ctrl.op = OP_BSET; ctrl.to_f = 1'b1; end
          2'b10:   begin ctrl.op = OP_BTST; ctrl.skip = SK_BIT0; end
          default: begin ctrl.op = OP_BTST; ctrl.skip = SK_BIT1; end
        endcase
      end
      2'b11: begin
        ctrl.use_lit = 1'b1;
        ctrl.to_w    = 1'b1;
        casez (instr[11:8])
          4'b111?: begin ctrl.op = OP_ADD; ctrl.upd_c = 1'b1; ctrl.upd_dc = 1'b1; ctrl.upd_z = 1'b1; end
          4'b110?: begin ctrl.op = OP_SUB; ctrl.upd_c = 1'b1; ctrl.upd_dc = 1'b1; ctrl.upd_z = 1'b1; end
          4'b1001: begin ctrl.op = OP_AND; ctrl.upd_z = 1'b1; end
          4'b1000: begin ctrl.op = OP_IOR; ctrl.upd_z = 1'b1; end
          4'b1010: begin ctrl.op = OP_XOR; ctrl.upd_z = 1'b1; end
          4'b0???: begin ctrl.op = OP_PASS; end
          default: begin ctrl.to_w = 1'b0; end
        endcase
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_exec_pkg::*;
(
  input  alu_op_e        op,
  input  logic [DW-1:0]  opa,
  input  logic [DW-1:0]  wv,
  input  logic           cin,
  input  logic [BIW-1:0] bsel,
  output logic [DW-1:0]  res,
  output logic           cout,
  output logic           dcout,
  output logic           zout,
  output logic           bit_val
);
  logic [DW:0]  wide;
  logic [NIB:0] low;
  logic [DW-1:0] mask;

  assign mask    = {{(DW-1){1'b0}}, 1'b1} << bsel;
  assign bit_val = opa[bsel];
  assign zout    = (res == '0);

  always_comb begin
    wide  = '0;
    low   = '0;
    res   = opa;
    cout  = cin;
    dcout = 1'b0;
    unique case (op)
      OP_ADD: begin
        wide = {1'b0, opa} + {1'b0, wv};
        low  = {1'b0, opa[NIB-1:0]} + {1'b0, wv[NIB-1:0]};
        res  = wide[DW-1:0]; cout = wide[DW]; dcout = low[NIB];
      end
      OP_SUB: begin
        wide = {1'b0, opa} + {1'b0, ~wv} + {{DW{1'b0}}, 1'b1};
        low  = {1'b0, opa[NIB-1:0]} + {1'b0, ~wv[NIB-1:0]} + {{NIB{1'b0}}, 1'b1};
        res  = wide[DW-1:0]; cout = wide[DW]; dcout = low[NIB];
      end
      OP_AND:   res = opa & wv;
      OP_IOR:   res = opa | wv;
      OP_XOR:   res = opa ^ wv;
      OP_CLR:   res = '0;
      OP_COM:   res = ~opa;
      OP_DEC:   res = opa - {{(DW-1){1'b0}}, 1'b1};
      OP_INC:   res = opa + {{(DW-1){1'b0}}, 1'b1};
      OP_PASSW: res = wv;
      OP_RL:    begin res = {opa[DW-2:0], cin}; cout = opa[DW-1]; end
      OP_RR:    begin res = {cin, opa[DW-1:1]}; cout = opa[0]; end
      OP_SWAP:  res = {opa[NIB-1:0], opa[DW-1:NIB]};
      OP_BCLR:  res = opa & ~mask;
      OP_BSET:  res = opa | mask;
      default:  res = opa;
    endcase
  end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_en,
  input  logic [IW-1:0] instr,
  input  logic [DW-1:0] file_rdata,
  output logic [AW-1:0] file_addr,
  output logic [DW-1:0] file_wdata,
  output logic          file_we,
  output logic [DW-1:0] w_reg,
  output logic          flag_c,
  output logic          flag_dc,
  output logic          flag_z,
  output logic          skip
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  ctrl_t         ctrl;
  logic [DW-1:0] opa, res;
  logic          c_new, dc_new, z_new, bit_val;
  logic [DW-1:0] w_q, w_d;
  logic          c_q, c_d, dc_q, dc_d, z_q, z_d;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  acc_decode u_dec (.instr(instr), .ctrl(ctrl));

  assign opa = ctrl.use_lit ? instr[DW-1:0] : file_rdata;

  acc_alu u_alu (
    .op(ctrl.op), .opa(opa), .wv(w_q), .cin(c_q), .bsel(instr[AW+BIW-1:AW]),
    .res(res), .cout(c_new), .dcout(dc_new), .zout(z_new), .bit_val(bit_val)
  );

  assign file_addr  = instr[AW-1:0];
  assign file_wdata = res;
  assign file_we    = exec_en & rst_int_n & ctrl.to_f;

  always_comb begin
    unique case (ctrl.skip)
      SK_ZERO: skip = exec_en & rst_int_n & z_new;
      SK_BIT0: skip = exec_en & rst_int_n & ~bit_val;
      SK_BIT1: skip = exec_en & rst_int_n & bit_val;
      default: skip = 1'b0;
    endcase
  end

  // next state
  always_comb begin
    w_d  = w_q;  c_d = c_q;  dc_d = dc_q;  z_d = z_q;
    if (exec_en) begin
      if (ctrl.to_w)   w_d  = res;
      if (ctrl.upd_c)  c_d  = c_new;
      if (ctrl.upd_dc) dc_d = dc_new;
      if (ctrl.upd_z)  z_d  = z_new;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      w_q <= '0; c_q <= 1'b0; dc_q <= 1'b0; z_q <= 1'b0;
    end else begin
      w_q <= w_d; c_q <= c_d; dc_q <= dc_d; z_q <= z_d;
    end
  end

  assign w_reg   = w_q;
  assign flag_c  = c_q;
  assign flag_dc = dc_q;
  assign flag_z  = z_q;

  // R12: strobe low means no side effects
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    !exec_en |-> (!file_we && !skip));
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    !exec_en |=> ($stable(w_reg) && $stable({flag_c, flag_dc, flag_z})));
  // R11: transfer class does nothing
  p_xfer_nop_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (exec_en && instr[13:12] == 2'b10) |-> (!file_we && !skip));
  p_xfer_hold_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (exec_en && instr[13:12] == 2'b10) |=> ($stable(w_reg) && $stable({flag_c, flag_dc, flag_z})));
  // R6: rotate carry comes from the bit shifted out
  p_rot_carry_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (exec_en && instr[13:9] == 5'b00110) |=>
      (flag_c == ($past(instr[8]) ? $past(file_rdata[DW-1]) : $past(file_rdata[0]))));
  // R9: bit tests never write
  p_btest_nowr_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (exec_en && instr[13:11] == 3'b011) |-> !file_we);
  // R7: nibble swap keeps flags
  p_swap_flags_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (exec_en && instr[13:8] == 6'b001110) |=> $stable({flag_c, flag_dc, flag_z}));
endmodule

// File: tb/acc_exec_unit_test.sv
`timescale 1ns/100ps
module acc_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exec_en;
  logic [13:0] instr;
  logic [7:0]  file_rdata;
  logic [6:0]  file_addr;
  logic [7:0]  file_wdata, w_reg;
  logic        file_we, flag_c, flag_dc, flag_z, skip;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  acc_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
    .file_rdata(file_rdata), .file_addr(file_addr), .file_wdata(file_wdata),
    .file_we(file_we), .w_reg(w_reg), .flag_c(flag_c), .flag_dc(flag_dc),
    .flag_z(flag_z), .skip(skip)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [13:0] ins;
    logic [7:0]  rd;
    logic [7:0]  w0;
    logic        c0;
    logic        we;
    logic [7:0]  wd;
    logic        sk;
    logic [7:0]  ew;
    logic        ec, edc, ez;
  } vec_t;

  // preset state before each row: W=w0, C=DC=c0, Z=1
  localparam int NV = 48;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  14'h0725, 8'h3A, 8'h28, 1'b0, 1'b0, 8'h00, 1'b0, 8'h62, 1'b0, 1'b1, 1'b0}, // R2 add to W
    '{4'd2,  14'h07A5, 8'hF0, 8'h10, 1'b0, 1'b1, 8'h00, 1'b0, 8'h10, 1'b1, 1'b0, 1'b1}, // R2 add to file
    '{4'd3,  14'h0225, 8'h50, 8'h20, 1'b0, 1'b0, 8'h00, 1'b0, 8'h30, 1'b1, 1'b1, 1'b0}, // R3 sub
    '{4'd3,  14'h02A5, 8'h10, 8'h20, 1'b1, 1'b1, 8'hF0, 1'b0, 8'h20, 1'b0, 1'b1, 1'b0}, // R3 borrow
    '{4'd3,  14'h0225, 8'h13, 8'h05, 1'b0, 1'b0, 8'h00, 1'b0, 8'h0E, 1'b1, 1'b0, 1'b0}, // R3 digit borrow
    '{4'd3,  14'h0225, 8'h44, 8'h44, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1}, // R3 equal
    '{4'd4,  14'h0525, 8'hF0, 8'h0F, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1}, // R4 and
    '{4'd4,  14'h04A5, 8'h50, 8'h05, 1'b1, 1'b1, 8'h55, 1'b0, 8'h05, 1'b1, 1'b1, 1'b0}, // R4 or
    '{4'd4,  14'h0625, 8'hFF, 8'h0F, 1'b0, 1'b0, 8'h00, 1'b0, 8'hF0, 1'b0, 1'b0, 1'b0}, // R4 xor
    '{4'd4,  14'h01A5, 8'h77, 8'h12, 1'b1, 1'b1, 8'h00, 1'b0, 8'h12, 1'b1, 1'b1, 1'b1}, // R4 clear file
    '{4'd4,  14'h0125, 8'h77, 8'h12, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R4 clear W
    '{4'd4,  14'h09A5, 8'h5A, 8'h33, 1'b0, 1'b1, 8'hA5, 1'b0, 8'h33, 1'b0, 1'b0, 1'b0}, // R4 complement
    '{4'd4,  14'h0825, 8'h00, 8'h99, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1}, // R4 move
    '{4'd5,  14'h03A5, 8'h01, 8'h11, 1'b0, 1'b1, 8'h00, 1'b0, 8'h11, 1'b0, 1'b0, 1'b1}, // R5 dec
    '{4'd5,  14'h0A25, 8'hFF, 8'h11, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1}, // R5 inc wrap
    '{4'd5,  14'h0BA5, 8'h01, 8'h22, 1'b0, 1'b1, 8'h00, 1'b1, 8'h22, 1'b0, 1'b0, 1'b1}, // R5 dec-skip zero
    '{4'd5,  14'h0F25, 8'h7F, 8'h22, 1'b0, 1'b0, 8'h00, 1'b0, 8'h80, 1'b0, 1'b0, 1'b1}, // R5 inc-skip Z held
    '{4'd5,  14'h0FA5, 8'hFF, 8'h22, 1'b1, 1'b1, 8'h00, 1'b1, 8'h22, 1'b1, 1'b1, 1'b1}, // R5 inc-skip zero
    '{4'd5,  14'h0B25, 8'h05, 8'h22, 1'b0, 1'b0, 8'h00, 1'b0, 8'h04, 1'b0, 1'b0, 1'b1}, // R5 dec-skip nonzero
    '{4'd6,  14'h0DA5, 8'h81, 8'h44, 1'b1, 1'b1, 8'h03, 1'b0, 8'h44, 1'b1, 1'b1, 1'b1}, // R6 rl
    '{4'd6,  14'h0D25, 8'h40, 8'h44, 1'b1, 1'b0, 8'h00, 1'b0, 8'h81, 1'b0, 1'b1, 1'b1}, // R6 rl into W
    '{4'd6,  14'h0C25, 8'h01, 8'h44, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1}, // R6 rr
    '{4'd6,  14'h0CA5, 8'h02, 8'h44, 1'b1, 1'b1, 8'h81, 1'b0, 8'h44, 1'b0, 1'b1, 1'b1}, // R6 rr carry in
    '{4'd7,  14'h0EA5, 8'h3C, 8'h10, 1'b0, 1'b1, 8'hC3, 1'b0, 8'h10, 1'b0, 1'b0, 1'b1}, // R7 swap
    '{4'd7,  14'h00A5, 8'h00, 8'h6B, 1'b1, 1'b1, 8'h6B, 1'b0, 8'h6B, 1'b1, 1'b1, 1'b1}, // R7 W to file
    '{4'd8,  14'h12A5, 8'hFF, 8'h01, 1'b0, 1'b1, 8'hDF, 1'b0, 8'h01, 1'b0, 1'b0, 1'b1}, // R8 clear bit 5
    '{4'd8,  14'h1425, 8'h00, 8'h02, 1'b1, 1'b1, 8'h01, 1'b0, 8'h02, 1'b1, 1'b1, 1'b1}, // R8 set bit 0
    '{4'd8,  14'h17A5, 8'h00, 8'h02, 1'b0, 1'b1, 8'h80, 1'b0, 8'h02, 1'b0, 1'b0, 1'b1}, // R8 set bit 7
    '{4'd9,  14'h19A5, 8'hF7, 8'h03, 1'b0, 1'b0, 8'h00, 1'b1, 8'h03, 1'b0, 1'b0, 1'b1}, // R9 test clear hit
    '{4'd9,  14'h19A5, 8'h08, 8'h03, 1'b0, 1'b0, 8'h00, 1'b0, 8'h03, 1'b0, 1'b0, 1'b1}, // R9 test clear miss
    '{4'd9,  14'h1F25, 8'h40, 8'h03, 1'b1, 1'b0, 8'h00, 1'b1, 8'h03, 1'b1, 1'b1, 1'b1}, // R9 test set hit
    '{4'd9,  14'h1F25, 8'hBF, 8'h03, 1'b1, 1'b0, 8'h00, 1'b0, 8'h03, 1'b1, 1'b1, 1'b1}, // R9 test set miss
    '{4'd10, 14'h3E09, 8'h00, 8'h07, 1'b0, 1'b0, 8'h00, 1'b0, 8'h10, 1'b0, 1'b1, 1'b0}, // R10 add lit
    '{4'd10, 14'h3F01, 8'h00, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1}, // R10 add lit alt
    '{4'd10, 14'h3C05, 8'h00, 8'h06, 1'b0, 1'b0, 8'h00, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0}, // R10 sub lit borrow
    '{4'd10, 14'h3D20, 8'h00, 8'h10, 1'b0, 1'b0, 8'h00, 1'b0, 8'h10, 1'b1, 1'b1, 1'b0}, // R10 sub lit
    '{4'd10, 14'h39F0, 8'h00, 8'h3C, 1'b1, 1'b0, 8'h00, 1'b0, 8'h30, 1'b1, 1'b1, 1'b0}, // R10 and lit
    '{4'd10, 14'h3800, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R10 or lit
    '{4'd10, 14'h3AFF, 8'h00, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R10 xor lit
    '{4'd10, 14'h3055, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h55, 1'b0, 1'b0, 1'b1}, // R10 load lit
    '{4'd10, 14'h33AA, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'hAA, 1'b1, 1'b1, 1'b1}, // R10 load lit alt
    '{4'd10, 14'h3477, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h77, 1'b0, 1'b0, 1'b1}, // R10 return lit
    '{4'd10, 14'h37E1, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'hE1, 1'b0, 1'b0, 1'b1}, // R10 return lit alt
    '{4'd11, 14'h0000, 8'hAA, 8'h5A, 1'b1, 1'b0, 8'h00, 1'b0, 8'h5A, 1'b1, 1'b1, 1'b1}, // R11 nop
    '{4'd11, 14'h0060, 8'hAA, 8'h5A, 1'b0, 1'b0, 8'h00, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b1}, // R11 nop variant
    '{4'd11, 14'h0008, 8'hAA, 8'h5A, 1'b1, 1'b0, 8'h00, 1'b0, 8'h5A, 1'b1, 1'b1, 1'b1}, // R11 byte 0000 d=0
    '{4'd11, 14'h2ABC, 8'hAA, 8'h5A, 1'b0, 1'b0, 8'h00, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b1}, // R11 transfer class
    '{4'd11, 14'h3B12, 8'hAA, 8'h5A, 1'b1, 1'b0, 8'h00, 1'b0, 8'h5A, 1'b1, 1'b1, 1'b1}  // R11 literal 1011
  };

  task automatic exec1(input logic [13:0] i, input logic [7:0] rd);
    @(negedge clk);
    instr = i; file_rdata = rd; exec_en = 1'b1;
    @(posedge clk);
  endtask

  task automatic preset(input logic [7:0] w0, input logic c0);
    if (c0) begin exec1(14'h30FF, 8'h00); exec1(14'h3E01, 8'h00); end
    else    begin exec1(14'h3000, 8'h00); exec1(14'h3E00, 8'h00); end
    exec1({6'b110000, w0}, 8'h00);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; exec_en = 1'b0; instr = '0; file_rdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset state", {w_reg, flag_c, flag_dc, flag_z, file_we, skip}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      vec_t v = VECS[k];
      string tag;
      tag = $sformatf("R%0d row %0d", v.req, k);
      preset(v.w0, v.c0);
      @(negedge clk);
      instr = v.ins; file_rdata = v.rd; exec_en = 1'b1;
      #1;
      if (v.we)
        check({tag, " write"}, {file_we, file_wdata, 1'b0, file_addr, skip},
              {1'b1, v.wd, 1'b0, v.ins[6:0], v.sk});
      else
        check({tag, " write"}, {file_we, skip}, {1'b0, v.sk});
      @(posedge clk); #1;
      exec_en = 1'b0;
      check({tag, " state"}, {w_reg, flag_c, flag_dc, flag_z}, {v.ew, v.ec, v.edc, v.ez});
    end

    // R12 strobe low: no write, no skip, no state change
    preset(8'h5C, 1'b1);
    @(negedge clk);
    instr = 14'h07A5; file_rdata = 8'h10; exec_en = 1'b0;
    #1 check("R12 idle write", {file_we, skip}, 2'b00);
    @(negedge clk);
    instr = 14'h1F25; file_rdata = 8'h40;
    #1 check("R12 idle skip", {file_we, skip}, 2'b00);
    @(posedge clk); #1;
    check("R12 idle hold", {w_reg, flag_c, flag_dc, flag_z}, {8'h5C, 3'b111});

    // R1 asynchronous reset mid-run
    @(negedge clk); #1;
    rst_n = 1'b0;
    #0.5 check("R1 async reset", {w_reg, flag_c, flag_dc, flag_z}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule